// File: doc/BRIEF.md
# Seven-Channel DMA Transfer Engine

This block moves data between a memory bus and a peripheral bus on behalf of seven independent channels. Each channel holds a peripheral-side address, a memory-side address, a remaining-transfer count and a control word. Software sets these through a small register port. A peripheral then asks for service on its own request line. One shared datapath carries out the transfers. Each transfer reads one item from the source side and then writes that item to the destination side.

A fixed-priority arbiter chooses among the channels that are ready. It decides only between transfers, so a read/write pair always completes for one channel. The peripheral side and the memory side each have their own data width and address-increment setting. A single transfer can therefore narrow or widen the data between source and destination. When the count reaches zero, the channel stops on its own. It then reports completion through a flag in its control word.

Top module: `dma_engine`

## Requirements
- R1: The register port selects a register with `cfg_addr = {channel[2:0], reg[1:0]}`. The register codes are 0 = peripheral address, 1 = memory address, 2 = remaining count (16 bits) and 3 = control. A write takes effect at the clock edge where `cfg_we` is high. `cfg_rdata` always returns the register that `cfg_addr` selects, zero-extended. After reset, every register reads zero and neither bus has a request raised.
- R2: The control word has these fields: bit 0 enable, bit 1 direction, bits 3:2 peripheral width, bits 5:4 memory width, bit 6 peripheral increment, bit 7 memory increment, and bit 8 done (it reads back and cannot be written). Width codes are 0 = 8 bits, 1 = 16 bits and 2 = 32 bits. Code 3 behaves as 32 bits.
- R3: Every transfer is a source read followed by a destination write. The destination write request is raised only after the source read has been acknowledged. The memory and peripheral requests are never high in the same cycle.
- R4: Direction 0 reads from the peripheral bus and writes to the memory bus. Direction 1 reads from the memory bus and writes to the peripheral bus. The memory bus always carries the channel's memory address, and the peripheral bus always carries its peripheral address.
- R5: Each bus's size output equals that side's width code. Data is right-aligned on both buses.
- R6: The read value is truncated to the source width. The written value is then truncated to the destination width. As a result, narrowing keeps the low-order bytes and widening zero-extends.
- R7: After each completed write, a side whose increment bit is set advances its address by its own width in bytes (1, 2 or 4). A side whose increment bit is clear keeps its address.
- R8: The remaining count decrements by one after each completed write. The write that brings it to zero clears enable and sets done. Any write to the control register clears done.
- R9: If a channel is enabled while its count is zero, it performs no bus transfer. Its enable clears and done sets.
- R10: When several channels are ready, the lowest-numbered one is served. Arbitration takes place only between transfers. A request that arrives during a transfer waits until that read/write pair has finished.
- R11: A channel is ready only when it is enabled, its request line is high and its count is nonzero. Otherwise its registers stay unchanged and it makes no bus transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Channel number and register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents |
| preq | input | 7 | Per-channel service request |
| m_req | output | 1 | Memory bus request, held until acknowledged |
| m_we | output | 1 | Memory bus write (1) or read (0) |
| m_addr | output | 32 | Memory bus address |
| m_size | output | 2 | Memory bus width code |
| m_wdata | output | 32 | Memory bus write data, right-aligned |
| m_ack | input | 1 | Memory bus acknowledge |
| m_rdata | input | 32 | Memory bus read data, valid with acknowledge |
| p_req | output | 1 | Peripheral bus request, held until acknowledged |
| p_we | output | 1 | Peripheral bus write (1) or read (0) |
| p_addr | output | 32 | Peripheral bus address |
| p_size | output | 2 | Peripheral bus width code |
| p_wdata | output | 32 | Peripheral bus write data, right-aligned |
| p_ack | input | 1 | Peripheral bus acknowledge |
| p_rdata | input | 32 | Peripheral bus read data, valid with acknowledge |

## Verification
The hardest case to reach from the ports is a higher-priority request that arrives after a lower-priority channel has finished its read but before its write has completed. The bench waits until its bus model logs the first read of channel 4, and only then raises channel 1's request. It expects channel 4's write to finish first, then a full transfer from channel 1, and only then the rest of channel 4's transfers. Acknowledge delays are random, which moves this window around from cycle to cycle. Randomly chosen width, increment and direction combinations exercise narrowing, widening and held addresses.

// File: rtl/dma_pkg.sv
// Shared constants, types and helpers for the DMA transfer engine.
// Assumes a 32-bit data path; widths are encoded on two bits.
package dma_pkg;
    localparam int DW        = 32;
    localparam int CTL_EN    = 0;
    localparam int CTL_DIR   = 1;
    localparam int CTL_PW    = 2;
    localparam int CTL_MW    = 4;
    localparam int CTL_PINC  = 6;
    localparam int CTL_MINC  = 7;
    localparam int CTL_DONE  = 8;

    localparam logic [1:0] SEL_PADDR = 2'd0;
    localparam logic [1:0] SEL_MADDR = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_CTRL  = 2'd3;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_STORE} mover_state_e;

    // Bytes moved per item for a width code (code 3 treated as 32 bits).
    function automatic logic [2:0] width_bytes(input logic [1:0] w);
        case (w)
            2'd0:    width_bytes = 3'd1;
            2'd1:    width_bytes = 3'd2;
            default: width_bytes = 3'd4;
        endcase
    endfunction

    // Low-order byte mask for a width code.
    function automatic logic [DW-1:0] width_mask(input logic [1:0] w);
        case (w)
            2'd0:    width_mask = 32'h0000_00FF;
            2'd1:    width_mask = 32'h0000_FFFF;
            default: width_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/dma_channel.sv
// One DMA channel: holds its addresses, remaining count and control word,
// advances them after each completed store, and flags readiness.
// Assumes software does not rewrite a channel while it is mid-transfer.
module dma_channel
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_sel,
    output logic [DW-1:0] rd_data,
    input  logic          preq,
    input  logic          adv,
    output logic          want,
    output logic [AW-1:0] paddr,
    output logic [AW-1:0] maddr,
    output logic          dir,
    output logic [1:0]    pw,
    output logic [1:0]    mw
);
    logic [AW-1:0] paddr_q, maddr_q;
    logic [CW-1:0] cnt_q;
    logic [7:0]    ctl_q;
    logic          done_q;
    logic [2:0]    pstep, mstep;

    assign pstep = ctl_q[CTL_PINC] ? width_bytes(ctl_q[CTL_PW +: 2]) : 3'd0;
    assign mstep = ctl_q[CTL_MINC] ? width_bytes(ctl_q[CTL_MW +: 2]) : 3'd0;

    // Register writes, post-store advance and zero-count shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            maddr_q <= '0;
            cnt_q   <= '0;
            ctl_q   <= '0;
            done_q  <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_PADDR: paddr_q <= wr_data[AW-1:0];
                SEL_MADDR: maddr_q <= wr_data[AW-1:0];
                SEL_COUNT: cnt_q   <= wr_data[CW-1:0];
                default: begin
                    ctl_q  <= wr_data[7:0];
                    done_q <= 1'b0;
                end
            endcase
        end else if (adv) begin
            cnt_q   <= cnt_q - 1'b1;
            paddr_q <= paddr_q + AW'(pstep);
            maddr_q <= maddr_q + AW'(mstep);
            if (cnt_q == CW'(1)) begin
                ctl_q[CTL_EN] <= 1'b0;
                done_q        <= 1'b1;
            end
        end else if (ctl_q[CTL_EN] && cnt_q == '0) begin
            ctl_q[CTL_EN] <= 1'b0;
            done_q        <= 1'b1;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (rd_sel)
            SEL_PADDR: rd_data = DW'(paddr_q);
            SEL_MADDR: rd_data = DW'(maddr_q);
            SEL_COUNT: rd_data = DW'(cnt_q);
            default:   rd_data = DW'({done_q, ctl_q});
        endcase
    end

    assign want  = ctl_q[CTL_EN] && preq && (cnt_q != '0);
    assign paddr = paddr_q;
    assign maddr = maddr_q;
    assign dir   = ctl_q[CTL_DIR];
    assign pw    = ctl_q[CTL_PW +: 2];
    assign mw    = ctl_q[CTL_MW +: 2];

    AST_COUNT_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en) |=> cnt_q == $past(cnt_q) - 1'b1); // R8
    AST_DONE_STOPS_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> !ctl_q[CTL_EN]); // R8
    AST_ADV_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (ctl_q[CTL_EN] && cnt_q != '0)); // R9
endmodule

// File: rtl/dma_arbiter.sv
// Fixed-priority arbiter: the lowest-numbered ready channel wins.
// Purely combinational; the clock only times its checks.
module dma_arbiter #(
    parameter int N  = 7,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    localparam logic [N-1:0] ONE = N'(1);
    logic [N-1:0] gnt;

    assign gnt = req & (~req + ONE);
    assign any = |req;

    // Encode the one-hot grant into a channel number.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = IW'(i);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt != '0) == any)); // R10
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> (((gnt - ONE) & req) == '0) && ((gnt & req) != '0)); // R10
endmodule

// File: rtl/dma_mover.sv
// Shared transfer datapath: latches the arbiter's winner, reads one item
// from the source bus, then writes it to the destination bus.
// Assumes each bus request is held until its acknowledge is seen.
module dma_mover
    import dma_pkg::*;
#(
    parameter int N  = 7,
    parameter int AW = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_req,
    input  logic [IW-1:0] win_idx,
    output logic [IW-1:0] sel_idx,
    input  logic [AW-1:0] paddr,
    input  logic [AW-1:0] maddr,
    input  logic          dir,
    input  logic [1:0]    pw,
    input  logic [1:0]    mw,
    output logic          adv,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [1:0]    m_size,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ack,
    input  logic [DW-1:0] m_rdata,
    output logic          p_req,
    output logic          p_we,
    output logic [AW-1:0] p_addr,
    output logic [1:0]    p_size,
    output logic [DW-1:0] p_wdata,
    input  logic          p_ack,
    input  logic [DW-1:0] p_rdata
);
    mover_state_e  state_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] data_q;
    logic          hs;
    logic [1:0]    srcw;
    logic [DW-1:0] rd;

    assign srcw    = dir ? mw : pw;
    assign rd      = dir ? m_rdata : p_rdata;
    assign m_req   = (state_q == ST_LOAD && dir) || (state_q == ST_STORE && !dir);
    assign p_req   = (state_q == ST_LOAD && !dir) || (state_q == ST_STORE && dir);
    assign m_we    = (state_q == ST_STORE);
    assign p_we    = (state_q == ST_STORE);
    assign m_addr  = maddr;
    assign p_addr  = paddr;
    assign m_size  = mw;
    assign p_size  = pw;
    assign m_wdata = data_q & width_mask(mw);
    assign p_wdata = data_q & width_mask(pw);
    assign hs      = (m_req && m_ack) || (p_req && p_ack);
    assign adv     = (state_q == ST_STORE) && hs;
    assign sel_idx = idx_q;

    // Sequence grant, load and store; capture the source item.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (any_req) begin
                    idx_q   <= win_idx;
                    state_q <= ST_LOAD;
                end
                ST_LOAD: if (hs) begin
                    data_q  <= rd & width_mask(srcw);
                    state_q <= ST_STORE;
                end
                default: if (hs) state_q <= ST_IDLE;
            endcase
        end
    end

    AST_ONE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_req && p_req)); // R3
    AST_MEM_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we) |-> ($past(p_req && p_ack) || $past(m_req && m_we))); // R3
    AST_PER_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && p_we) |-> ($past(m_req && m_ack) || $past(p_req && p_we))); // R3
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q == ST_IDLE || $stable(idx_q))); // R10
endmodule

// File: rtl/dma_engine.sv
// Top of the seven-channel DMA engine: register decode, channel array,
// arbiter and shared mover. Channel fields reach the mover through a
// multiplexer steered by the mover's latched channel number.
module dma_engine
    import dma_pkg::*;
#(
    parameter int NCH = 7,
    parameter int AW  = 32,
    parameter int CW  = 16,
    localparam int CHW = $clog2(NCH),
    localparam int CAW = CHW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CAW-1:0] cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    input  logic [NCH-1:0] preq,
    output logic           m_req,
    output logic           m_we,
    output logic [AW-1:0]  m_addr,
    output logic [1:0]     m_size,
    output logic [DW-1:0]  m_wdata,
    input  logic           m_ack,
    input  logic [DW-1:0]  m_rdata,
    output logic           p_req,
    output logic           p_we,
    output logic [AW-1:0]  p_addr,
    output logic [1:0]     p_size,
    output logic [DW-1:0]  p_wdata,
    input  logic           p_ack,
    input  logic [DW-1:0]  p_rdata
);
    logic [CHW-1:0] cfg_ch;
    logic [1:0]     cfg_sel;
    logic [NCH-1:0] want;
    logic [DW-1:0]  ch_rd    [NCH];
    logic [AW-1:0]  ch_paddr [NCH];
    logic [AW-1:0]  ch_maddr [NCH];
    logic           ch_dir   [NCH];
    logic [1:0]     ch_pw    [NCH];
    logic [1:0]     ch_mw    [NCH];
    logic           any_req, adv;
    logic [CHW-1:0] win_idx, sel_idx;

    assign cfg_ch  = cfg_addr[CAW-1:2];
    assign cfg_sel = cfg_addr[1:0];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma_channel #(.AW(AW), .CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && cfg_ch == CHW'(i)),
            .wr_sel  (cfg_sel),
            .wr_data (cfg_wdata),
            .rd_sel  (cfg_sel),
            .rd_data (ch_rd[i]),
            .preq    (preq[i]),
            .adv     (adv && sel_idx == CHW'(i)),
            .want    (want[i]),
            .paddr   (ch_paddr[i]),
            .maddr   (ch_maddr[i]),
            .dir     (ch_dir[i]),
            .pw      (ch_pw[i]),
            .mw      (ch_mw[i])
        );
    end

    // Unused channel numbers read as zero.
    assign cfg_rdata = (int'(cfg_ch) < NCH) ? ch_rd[cfg_ch] : '0;

    dma_arbiter #(.N(NCH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (want),
        .any   (any_req),
        .idx   (win_idx)
    );

    dma_mover #(.N(NCH), .AW(AW)) u_mov (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_req (any_req),
        .win_idx (win_idx),
        .sel_idx (sel_idx),
        .paddr   (ch_paddr[sel_idx]),
        .maddr   (ch_maddr[sel_idx]),
        .dir     (ch_dir[sel_idx]),
        .pw      (ch_pw[sel_idx]),
        .mw      (ch_mw[sel_idx]),
        .adv     (adv),
        .m_req   (m_req),
        .m_we    (m_we),
        .m_addr  (m_addr),
        .m_size  (m_size),
        .m_wdata (m_wdata),
        .m_ack   (m_ack),
        .m_rdata (m_rdata),
        .p_req   (p_req),
        .p_we    (p_we),
        .p_addr  (p_addr),
        .p_size  (p_size),
        .p_wdata (p_wdata),
        .p_ack   (p_ack),
        .p_rdata (p_rdata)
    );
endmodule

// File: tb/dma_engine_tb.sv
`timescale 1ns/1ps
// Bench for the DMA engine: random-latency bus models log every access;
// expected sequences come from bench functions written from the requirements.
module dma_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [6:0]  preq = '0;
    logic        m_req, m_we, p_req, p_we;
    logic [31:0] m_addr, p_addr, m_wdata, p_wdata, m_rdata, p_rdata;
    logic [1:0]  m_size, p_size;
    logic        m_ack = 1'b0, p_ack = 1'b0;

    int n_chk = 0, n_bad = 0;
    int n_w = 0, n_r = 0;
    logic        lw_bus [0:1023];
    logic [31:0] lw_addr[0:1023];
    logic [31:0] lw_data[0:1023];
    logic [1:0]  lw_size[0:1023];
    logic        lr_bus [0:1023];
    logic [31:0] lr_addr[0:1023];
    logic [1:0]  lr_size[0:1023];

    always #2 clk = ~clk;

    dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .preq(preq),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size),
        .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata),
        .p_req(p_req), .p_we(p_we), .p_addr(p_addr), .p_size(p_size),
        .p_wdata(p_wdata), .p_ack(p_ack), .p_rdata(p_rdata)
    );

    // Bus 0 = memory, bus 1 = peripheral.
    function automatic logic [31:0] rdfun(input logic [31:0] a, input logic bus);
        return (a * 32'h0100_0193) ^ (bus ? 32'h5A5A_0000 : 32'h00C3_0000) ^ 32'h8000_0081;
    endfunction
    function automatic int fbytes(input logic [1:0] w);
        return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    endfunction
    function automatic logic [31:0] fmask(input logic [1:0] w);
        return (w == 2'd0) ? 32'hFF : (w == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    assign m_rdata = rdfun(m_addr, 1'b0);
    assign p_rdata = rdfun(p_addr, 1'b1);

    // Bus models: log each access when its acknowledge is granted.
    always @(negedge clk) begin
        if (m_req && !m_ack && ($urandom % 3 != 0)) begin
            if (m_we) begin
                lw_bus[n_w] = 1'b0; lw_addr[n_w] = m_addr; lw_data[n_w] = m_wdata; lw_size[n_w] = m_size; n_w++;
            end else begin
                lr_bus[n_r] = 1'b0; lr_addr[n_r] = m_addr; lr_size[n_r] = m_size; n_r++;
            end
            m_ack = 1'b1;
        end else m_ack = 1'b0;
        if (p_req && !p_ack && ($urandom % 3 != 0)) begin
            if (p_we) begin
                lw_bus[n_w] = 1'b1; lw_addr[n_w] = p_addr; lw_data[n_w] = p_wdata; lw_size[n_w] = p_size; n_w++;
            end else begin
                lr_bus[n_r] = 1'b1; lr_addr[n_r] = p_addr; lr_size[n_r] = p_size; n_r++;
            end
            p_ack = 1'b1;
        end else p_ack = 1'b0;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic cfg_wr(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'((ch << 2) | sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input int ch, input int sel, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = 5'((ch << 2) | sel);
        #1 d = cfg_rdata;
    endtask

    function automatic logic [31:0] ctlw(input logic en, input logic dir, input logic [1:0] pw,
                                          input logic [1:0] mw, input logic pi, input logic mi);
        return {24'd0, mi, pi, mw, pw, dir, en};
    endfunction

    // Check log entries wi/ri against step j of a channel's programme.
    task automatic chk_step(input string tag, input int wi, input int ri, input int j,
                            input logic dir, input logic [1:0] pw, input logic [1:0] mw,
                            input logic pi, input logic mi, input logic [31:0] pa, input logic [31:0] ma);
        logic [31:0] paj, maj, sa, da, ed;
        logic [1:0]  sw, dw;
        paj = pa + (pi ? 32'(fbytes(pw) * j) : 32'd0);
        maj = ma + (mi ? 32'(fbytes(mw) * j) : 32'd0);
        sa = dir ? maj : paj;  da = dir ? paj : maj;
        sw = dir ? mw : pw;    dw = dir ? pw : mw;
        ed = rdfun(sa, !dir) & fmask(sw) & fmask(dw);
        chk({tag, " R4 read bus"},   32'(lr_bus[ri]), 32'(!dir));
        chk({tag, " R7 read addr"},  lr_addr[ri], sa);
        chk({tag, " R5 read size"},  32'(lr_size[ri]), 32'(sw));
        chk({tag, " R4 write bus"},  32'(lw_bus[wi]), 32'(dir));
        chk({tag, " R7 write addr"}, lw_addr[wi], da);
        chk({tag, " R6 write data"}, lw_data[wi], ed);
        chk({tag, " R5 write size"}, 32'(lw_size[wi]), 32'(dw));
    endtask

    task automatic wait_done(input int ch);
        logic [31:0] d;
        for (int t = 0; t < 3000; t++) begin
            cfg_rd(ch, 3, d);
            if (d[8]) break;
        end
    endtask

    task automatic program_ch(input int ch, input logic [31:0] pa, input logic [31:0] ma, input int cnt,
                              input logic dir, input logic [1:0] pw, input logic [1:0] mw,
                              input logic pi, input logic mi);
        cfg_wr(ch, 0, pa);
        cfg_wr(ch, 1, ma);
        cfg_wr(ch, 2, 32'(cnt));
        cfg_wr(ch, 3, ctlw(1'b1, dir, pw, mw, pi, mi));
    endtask

    // Single-channel run with full sequence and final-register checks.
    task automatic run_one(input string tag, input int ch, input logic [31:0] pa, input logic [31:0] ma,
                           input int cnt, input logic dir, input logic [1:0] pw, input logic [1:0] mw,
                           input logic pi, input logic mi);
        int wb, rb;
        logic [31:0] d;
        program_ch(ch, pa, ma, cnt, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0);
        cfg_wr(ch, 3, ctlw(1'b1, dir, pw, mw, pi, mi));
        wb = n_w; rb = n_r;
        preq[ch] = 1'b1;
        wait_done(ch);
        preq[ch] = 1'b0;
        repeat (3) @(negedge clk);
        chk({tag, " R8 write count"}, 32'(n_w - wb), 32'(cnt));
        chk({tag, " R3 read count"},  32'(n_r - rb), 32'(cnt));
        for (int j = 0; j < cnt; j++) chk_step(tag, wb + j, rb + j, j, dir, pw, mw, pi, mi, pa, ma);
        cfg_rd(ch, 2, d); chk({tag, " R8 count zero"}, d, 32'd0);
        cfg_rd(ch, 3, d); chk({tag, " R8 done set en clear"}, {d[8], d[0]}, 32'b10);
        cfg_rd(ch, 0, d); chk({tag, " R7 final paddr"}, d, pa + (pi ? 32'(fbytes(pw) * cnt) : 32'd0));
        cfg_rd(ch, 1, d); chk({tag, " R7 final maddr"}, d, ma + (mi ? 32'(fbytes(mw) * cnt) : 32'd0));
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int wb, rb;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 no request after reset", {31'd0, m_req | p_req}, 32'd0);
        for (int c = 0; c < 7; c++)
            for (int s = 0; s < 4; s++) begin
                cfg_rd(c, s, d);
                chk("R1 register zero after reset", d, 32'd0);
            end

        // R1 readback
        cfg_wr(3, 0, 32'hDEAD_BEE1);
        cfg_wr(3, 1, 32'h1234_5678);
        cfg_wr(3, 2, 32'hFFFF_ABCD);
        cfg_rd(3, 0, d); chk("R1 paddr readback", d, 32'hDEAD_BEE1);
        cfg_rd(3, 1, d); chk("R1 maddr readback", d, 32'h1234_5678);
        cfg_rd(3, 2, d); chk("R1 count readback 16 bits", d, 32'h0000_ABCD);
        cfg_wr(3, 3, 32'h0000_01FE);
        cfg_rd(3, 3, d); chk("R2 ctrl readback done not writable", d, 32'h0000_00FE);

        // Directed width and direction corners
        run_one("narrow p32->m8",  0, 32'h4000_0000, 32'h2000_0100, 4, 1'b0, 2'd2, 2'd0, 1'b1, 1'b1);
        run_one("widen m8->p32",   6, 32'h4000_1000, 32'h2000_0200, 3, 1'b1, 2'd2, 2'd0, 1'b0, 1'b1);
        run_one("fixed both m16",  2, 32'h4000_2000, 32'h2000_0300, 2, 1'b0, 2'd1, 2'd1, 1'b0, 1'b0);

        // R8 control write clears done
        cfg_wr(2, 3, 32'd0);
        cfg_rd(2, 3, d); chk("R8 ctrl write clears done", d, 32'd0);

        // R9 zero count: no transfer
        wb = n_w;
        cfg_wr(5, 2, 32'd0);
        preq[5] = 1'b1;
        cfg_wr(5, 3, ctlw(1'b1, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1));
        repeat (20) @(negedge clk);
        preq[5] = 1'b0;
        chk("R9 zero count makes no write", 32'(n_w - wb), 32'd0);
        cfg_rd(5, 3, d); chk("R9 zero count done set en clear", {d[8], d[0]}, 32'b10);

        // R11 no request: nothing happens
        wb = n_w;
        cfg_wr(4, 0, 32'h4000_3000);
        cfg_wr(4, 2, 32'd2);
        cfg_wr(4, 3, ctlw(1'b1, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1));
        repeat (20) @(negedge clk);
        chk("R11 idle request no write", 32'(n_w - wb), 32'd0);
        cfg_rd(4, 2, d); chk("R11 count unchanged", d, 32'd2);
        cfg_rd(4, 0, d); chk("R11 paddr unchanged", d, 32'h4000_3000);
        cfg_wr(4, 3, 32'd0);

        // R10 simultaneous requests: channel 2 before channel 5
        program_ch(5, 32'h5000_0000, 32'h3500_0000, 2, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1);
        program_ch(2, 32'h5200_0000, 32'h3200_0000, 2, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1);
        wb = n_w; rb = n_r;
        @(negedge clk); preq[2] = 1'b1; preq[5] = 1'b1;
        wait_done(5);
        wait_done(2);
        preq = '0;
        chk("R10 four writes", 32'(n_w - wb), 32'd4);
        chk_step("R10 ch2 first",  wb,     rb,     0, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 32'h5200_0000, 32'h3200_0000);
        chk_step("R10 ch2 second", wb + 1, rb + 1, 1, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 32'h5200_0000, 32'h3200_0000);
        chk_step("R10 ch5 third",  wb + 2, rb + 2, 0, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 32'h5000_0000, 32'h3500_0000);
        chk_step("R10 ch5 fourth", wb + 3, rb + 3, 1, 1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 32'h5000_0000, 32'h3500_0000);

        // R10 higher priority arriving mid-transfer waits for the store
        program_ch(4, 32'h6400_0000, 32'h3400_0000, 3, 1'b1, 2'd1, 2'd2, 1'b1, 1'b1);
        program_ch(1, 32'h6100_0000, 32'h3100_0000, 1, 1'b1, 2'd1, 2'd2, 1'b1, 1'b1);
        wb = n_w; rb = n_r;
        preq[4] = 1'b1;
        for (int t = 0; t < 1000; t++) begin
            @(negedge clk);
            if (n_r > rb) break;
        end
        preq[1] = 1'b1;
        wait_done(4);
        wait_done(1);
        preq = '0;
        chk("R10 mid four writes", 32'(n_w - wb), 32'd4);
        chk_step("R10 mid ch4 j0", wb,     rb,     0, 1'b1, 2'd1, 2'd2, 1'b1, 1'b1, 32'h6400_0000, 32'h3400_0000);
        chk_step("R10 mid ch1 j0", wb + 1, rb + 1, 0, 1'b1, 2'd1, 2'd2, 1'b1, 1'b1, 32'h6100_0000, 32'h3100_0000);
        chk_step("R10 mid ch4 j1", wb + 2, rb + 2, 1, 1'b1, 2'd1, 2'd2, 1'b1, 1'b1, 32'h6400_0000, 32'h3400_0000);
        chk_step("R10 mid ch4 j2", wb + 3, rb + 3, 2, 1'b1, 2'd1, 2'd2, 1'b1, 1'b1, 32'h6400_0000, 32'h3400_0000);

        // Random programmes
        for (int it = 0; it < 24; it++) begin
            int ch, cnt;
            logic [31:0] pa, ma;
            ch  = int'($urandom % 7);
            cnt = 1 + int'($urandom % 5);
            pa  = {4'h4, 12'($urandom), 12'($urandom), 4'h0};
            ma  = {4'h2, 12'($urandom), 12'($urandom), 4'h0};
            run_one("random R6 R7", ch, pa, ma, cnt, 1'($urandom), 2'($urandom % 3), 2'($urandom % 3),
                    1'($urandom), 1'($urandom));
        end

        chk("R3 no request when idle", {30'd0, m_req, p_req}, 32'd0);
        finish_run();
    end
endmodule